// File: doc/BRIEF.md
# Issue Queue Tag Wakeup and Select

This block holds instructions that wait for their source operands. Dispatch places a new instruction into a chosen slot. The instruction carries up to `NSRC` source operands, and each operand has a tag and a ready flag. Every cycle, completing instructions broadcast their result tags on up to `NBCAST` ports. Each waiting operand is compared against every active port at once. A match on any port marks that operand ready.

A fixed-priority selector grants slots whose valid operands are all ready. Slot 0 has the highest priority. The selector grants at most `IWIDTH` slots per cycle, and each granted slot is freed at the next edge. A run-time `narrow` input halves two things: the number of broadcast ports that are listened to, and the per-cycle grant limit. This lets the core shrink wakeup and issue activity while it waits on a long miss. A `flush` input empties the queue in a single cycle.

Top module: `iq_wakeup_sel`

## Requirements
- R1: When `disp_valid` is high and `flush` is low, the slot at `disp_idx` becomes occupied. It stores the per-source valid flags, tags and ready flags. A source that is flagged ready, or whose valid flag is clear, needs no wakeup.
- R2: Consider an occupied slot with a valid source that is not ready. If its tag equals `bc_tag` on an active port whose `bc_valid` bit is high, the source becomes ready at the next edge. The slot can be granted from the cycle after that broadcast. Port p occupies bits `[p*TAGW +: TAGW]`.
- R3: A broadcast whose tag matches a source of the slot being dispatched in the same cycle stores that source as ready.
- R4: `issue_grant` is combinational from the stored state. A slot can be granted only if it is occupied and all of its valid sources are ready. A slot is therefore never granted in its dispatch cycle.
- R5: Eligible slots are granted in order of increasing index. The limit is `IWIDTH` grants per cycle (4 by default).
- R6: With `narrow` high, broadcast ports `NBCAST/2` and above are ignored. The grant limit becomes `IWIDTH/2`.
- R7: A granted slot is freed at the next edge, so it is not granted again.
- R8: While `flush` is high, `issue_grant` is zero. At the next edge every slot is emptied, and a dispatch in that cycle is dropped.
- R9: During and after reset the queue is empty and `issue_grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole queue |
| narrow | input | 1 | Halve the active broadcast ports and the grant limit |
| disp_valid | input | 1 | Dispatch write this cycle |
| disp_idx | input | $clog2(DEPTH) | Slot written by dispatch |
| disp_src_vld | input | NSRC | Per-source valid flags |
| disp_src_rdy | input | NSRC | Per-source ready-at-dispatch flags |
| disp_src_tag | input | NSRC*TAGW | Per-source tags, source s at [s*TAGW +: TAGW] |
| bc_valid | input | NBCAST | Per-port broadcast valid |
| bc_tag | input | NBCAST*TAGW | Broadcast tags, port p at [p*TAGW +: TAGW] |
| issue_grant | output | DEPTH | One bit per slot granted this cycle |

## Verification
The assertions take for granted that dispatch targets only a slot that is empty, or one that is being granted in the same cycle. The design overwrites an occupied slot without complaint. The random stimulus keeps its own occupancy model and picks `disp_idx` only among slots that the model shows to be free. When no slot is free it holds `disp_valid` low. Tags are drawn from a small range so that wakeups are frequent. The bench toggles `narrow` and `flush` freely, because the block accepts any value on those inputs.

// File: rtl/iq_wakeup_sel.sv
module iq_wakeup_sel #(
  parameter int DEPTH  = 8,
  parameter int NSRC   = 2,
  parameter int TAGW   = 6,
  parameter int NBCAST = 4,
  parameter int IWIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     narrow,
  input  logic                     disp_valid,
  input  logic [$clog2(DEPTH)-1:0] disp_idx,
  input  logic [NSRC-1:0]          disp_src_vld,
  input  logic [NSRC-1:0]          disp_src_rdy,
  input  logic [NSRC*TAGW-1:0]     disp_src_tag,
  input  logic [NBCAST-1:0]        bc_valid,
  input  logic [NBCAST*TAGW-1:0]   bc_tag,
  output logic [DEPTH-1:0]         issue_grant
);
  localparam int HALF_BC = NBCAST / 2;
  localparam int HALF_IW = IWIDTH / 2;

  logic [DEPTH-1:0]                 valid_q;
  logic [NSRC-1:0]                  svld_q [DEPTH];
  logic [NSRC-1:0]                  srdy_q [DEPTH];
  logic [NSRC-1:0][TAGW-1:0]        stag_q [DEPTH];
  logic [NSRC-1:0]                  hit    [DEPTH];
  logic [NSRC-1:0]                  disp_hit;
  logic [NBCAST-1:0]                port_on;
  logic [DEPTH-1:0]                 eligible;
  int                               limit;

  for (genvar p = 0; p < NBCAST; p++) begin : g_port
    assign port_on[p] = bc_valid[p] & (~narrow | (p < HALF_BC));
  end

  function automatic logic tag_hit(input logic [TAGW-1:0] t,
                                   input logic [NBCAST-1:0] on,
                                   input logic [NBCAST*TAGW-1:0] tags);
    logic h = 1'b0;
    for (int p = 0; p < NBCAST; p++)
      h |= on[p] & (tags[p*TAGW +: TAGW] == t);
    return h;
  endfunction

  always_comb begin
    for (int d = 0; d < DEPTH; d++)
      for (int s = 0; s < NSRC; s++)
        hit[d][s] = tag_hit(stag_q[d][s], port_on, bc_tag);
    for (int s = 0; s < NSRC; s++)
      disp_hit[s] = tag_hit(disp_src_tag[s*TAGW +: TAGW], port_on, bc_tag);
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_elig
    assign eligible[d] = valid_q[d] & (&(srdy_q[d] | ~svld_q[d]));
  end

  assign limit = narrow ? HALF_IW : IWIDTH;

  always_comb begin
    int cnt;
    cnt = 0;
    issue_grant = '0;
    if (!flush)
      for (int d = 0; d < DEPTH; d++)
        if (eligible[d] && cnt < limit) begin
          issue_grant[d] = 1'b1;
          cnt++;
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        svld_q[d] <= '0;
        srdy_q[d] <= '0;
        stag_q[d] <= '0;
      end
    end else begin
      for (int d = 0; d < DEPTH; d++) begin
        srdy_q[d] <= srdy_q[d] | hit[d];
        if (issue_grant[d]) valid_q[d] <= 1'b0;
      end
      if (disp_valid) begin
        valid_q[disp_idx] <= 1'b1;
        svld_q[disp_idx]  <= disp_src_vld;
        srdy_q[disp_idx]  <= disp_src_rdy | disp_hit;
        for (int s = 0; s < NSRC; s++)
          stag_q[disp_idx][s] <= disp_src_tag[s*TAGW +: TAGW];
      end
    end
  end

  assert_grant_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue_grant) <= limit);

  assert_narrow_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> $countones(issue_grant) <= HALF_IW);

  assert_grant_occupied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant & ~valid_q) == '0);

  assert_no_starve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && $countones(issue_grant) < limit) |-> (eligible & ~issue_grant) == '0);

  assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant != '0 && !disp_valid) |=> (valid_q & $past(issue_grant)) == '0);

  assert_flush_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> issue_grant == '0);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);
endmodule

// File: tb/tb_iq_wakeup_sel.sv
module tb_iq_wakeup_sel;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8, S = 2, T = 6, B = 4, W = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush, narrow, disp_valid;
  logic [$clog2(D)-1:0] disp_idx;
  logic [S-1:0] disp_src_vld, disp_src_rdy;
  logic [S*T-1:0] disp_src_tag;
  logic [B-1:0] bc_valid;
  logic [B*T-1:0] bc_tag;
  logic [D-1:0] issue_grant;

  int checks = 0, errors = 0;
  bit done = 0;

  logic         m_v   [D];
  logic [S-1:0] m_sv  [D];
  logic [S-1:0] m_sr  [D];
  logic [T-1:0] m_tag [D][S];

  iq_wakeup_sel #(.DEPTH(D), .NSRC(S), .TAGW(T), .NBCAST(B), .IWIDTH(W)) dut (
    .clk, .rst_n, .flush, .narrow, .disp_valid, .disp_idx, .disp_src_vld,
    .disp_src_rdy, .disp_src_tag, .bc_valid, .bc_tag, .issue_grant);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic bhit(input logic [T-1:0] t);
    for (int p = 0; p < B; p++)
      if (bc_valid[p] && (!narrow || p < B/2) && bc_tag[p*T +: T] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [D-1:0] exp_grant();
    logic [D-1:0] g = '0;
    int cnt = 0;
    int lim = narrow ? W/2 : W;
    if (flush) return g;
    for (int d = 0; d < D; d++)
      if (m_v[d] && ((m_sr[d] | ~m_sv[d]) == '1) && cnt < lim) begin
        g[d] = 1'b1;
        cnt++;
      end
    return g;
  endfunction

  task automatic check(string req, logic [D-1:0] act, logic [D-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s issue_grant actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    flush = 0; disp_valid = 0; disp_idx = '0; disp_src_vld = '0;
    disp_src_rdy = '0; disp_src_tag = '0; bc_valid = '0; bc_tag = '0;
  endtask

  task automatic disp(int idx, logic [S-1:0] vld, logic [S-1:0] rdy, int t0, int t1);
    disp_valid = 1; disp_idx = idx[$clog2(D)-1:0]; disp_src_vld = vld;
    disp_src_rdy = rdy; disp_src_tag = {t1[T-1:0], t0[T-1:0]};
  endtask

  task automatic bcast(int port, int tag);
    bc_valid[port] = 1'b1;
    bc_tag[port*T +: T] = tag[T-1:0];
  endtask

  // Inputs are driven at the falling edge; grants are sampled 1 time unit later.
  task automatic step(string req, bit fixed = 0, logic [D-1:0] fv = '0);
    logic [D-1:0] eg;
    logic [S-1:0] dh;
    #1;
    eg = exp_grant();
    if (fixed) check(req, issue_grant, fv);
    check(req, issue_grant, eg);
    for (int s = 0; s < S; s++) dh[s] = bhit(disp_src_tag[s*T +: T]);
    if (flush) begin
      for (int d = 0; d < D; d++) m_v[d] = 0;
    end else begin
      for (int d = 0; d < D; d++) begin
        for (int s = 0; s < S; s++) if (bhit(m_tag[d][s])) m_sr[d][s] = 1'b1;
        if (eg[d]) m_v[d] = 0;
      end
      if (disp_valid) begin
        m_v[disp_idx] = 1; m_sv[disp_idx] = disp_src_vld;
        m_sr[disp_idx] = disp_src_rdy | dh;
        for (int s = 0; s < S; s++) m_tag[disp_idx][s] = disp_src_tag[s*T +: T];
      end
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); narrow = 0;
    for (int d = 0; d < D; d++) begin m_v[d] = 0; m_sv[d] = '0; m_sr[d] = '0; m_tag[d][0] = '0; m_tag[d][1] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", issue_grant, '0);
    rst_n = 1;
    step("R9", 1, '0);

    // R1: ready operands at dispatch, granted next cycle; R7: then freed
    disp(3, 2'b11, 2'b11, 1, 2); step("R1", 1, '0);
    step("R1", 1, 8'h08);
    step("R7", 1, '0);

    // R3: same-cycle match wakes the slot being written
    disp(0, 2'b01, 2'b00, 5, 0); bcast(1, 5); step("R3", 1, '0);
    step("R3", 1, 8'h01);

    // R2: two pending sources woken on different ports
    disp(1, 2'b11, 2'b00, 7, 9); step("R2", 1, '0);
    bcast(0, 7); step("R2", 1, '0);
    step("R2", 1, '0);
    bcast(3, 9); step("R2", 1, '0);
    step("R2", 1, 8'h02);

    // R6: narrow ignores upper ports
    narrow = 1;
    disp(2, 2'b01, 2'b00, 11, 0); step("R6", 1, '0);
    bcast(2, 11); bcast(3, 11); step("R6", 1, '0);
    step("R6", 1, '0);
    bcast(1, 11); step("R6", 1, '0);
    step("R6", 1, 8'h04);
    narrow = 0;

    // R5: six slots woken together, limit 4 in full width
    for (int i = 0; i < 6; i++) begin disp(i, 2'b01, 2'b00, 20, 0); step("R5", 1, '0); end
    bcast(0, 20); step("R5", 1, '0);
    step("R5", 1, 8'h0F);
    step("R5", 1, 8'h30);
    step("R5", 1, '0);

    // R6: same with narrow, limit 2
    narrow = 1;
    for (int i = 0; i < 6; i++) begin disp(i, 2'b01, 2'b00, 21, 0); step("R6", 1, '0); end
    bcast(0, 21); step("R6", 1, '0);
    step("R6", 1, 8'h03);
    step("R6", 1, 8'h0C);
    step("R6", 1, 8'h30);
    step("R6", 1, '0);
    narrow = 0;

    // R8: flush suppresses grants, empties slots, drops dispatch
    for (int i = 0; i < 3; i++) begin disp(i, 2'b01, 2'b00, 30, 0); step("R8", 1, '0); end
    disp(5, 2'b01, 2'b00, 31, 0); step("R8", 1, '0);
    bcast(0, 30); step("R8", 1, '0);
    flush = 1; disp(4, 2'b11, 2'b11, 0, 0); step("R8", 1, '0);
    step("R8", 1, '0);
    bcast(0, 30); bcast(1, 31); step("R8", 1, '0);
    step("R8", 1, '0);

    // R4: random traffic checked against the bench model
    for (int c = 0; c < 4000; c++) begin
      int start;
      narrow = ($urandom % 8) == 0 ? ~narrow : narrow;
      flush = ($urandom % 64) == 0;
      start = $urandom % D;
      if ($urandom % 10 < 6)
        for (int k = 0; k < D; k++) begin
          int idx = (start + k) % D;
          if (!m_v[idx] && !disp_valid)
            disp(idx, $urandom % 4, ($urandom % 10 < 3) ? $urandom % 4 : 0,
                 $urandom % 12, $urandom % 12);
        end
      for (int p = 0; p < B; p++) if ($urandom % 10 < 4) bcast(p, $urandom % 12);
      step("R4");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule